// File: doc/BRIEF.md
# Random-Walk Inverse Element Estimator

This block estimates a single entry b(i,j) of the inverse of a small square matrix by averaging a fixed number of random walks. The matrix is prepared beforehand as a per-row scale table E and a table of entry signs. A walk begins at row i with a weight of one. At each step the walk obtains its next state from an external transition generator through a request/valid handshake. The weight is then multiplied by the scale of the row being left and by the sign of the entry for the move. Whenever the walk enters column j, the new weight is added to a running sum. When every walk has finished, the sum is shifted right by log2 of the walk count, and the block presents the estimate with a one-cycle done pulse.

All arithmetic is signed fixed point. Weights have W_W bits, FRAC_W of which are fractional. Scales are unsigned with the same fractional width. Both tables are outside the block and are read combinationally: the scale port is addressed by the current state, and the sign port is addressed by the (current, offered next) pair. The walk count is 2^N_LOG2 and the walk length is T_LEN.

The controller moves through five states. IDLE waits for start. SEED loads the walk start. STEP waits for a transition. FIN forms the average. DONE pulses the result. The transitions are: IDLE→SEED on start; SEED→STEP always; STEP→STEP on an accepted transition that is not the last of a walk; STEP→SEED on the last transition of a walk that is not the final walk; STEP→FIN on the last transition of the final walk; FIN→DONE always; DONE→IDLE always.

Top module: `mc_inv_est`

## Requirements
- R1: After reset, busy, nx_req and done are 0 and est is 0.
- R2: A start pulse in IDLE latches row_i and col_j. The first transition request of every walk presents nx_cur equal to the latched row. Each later request presents the state delivered by the previous accepted transition.
- R3: Each walk accepts exactly T_LEN transitions, and exactly 2^N_LOG2 walks run. After the final accepted transition, nx_req is 0 until the next start.
- R4: On an accepted transition with current state k and next state n, the new weight is (w × scl_val) arithmetically shifted right by FRAC_W, where scl_val is read at scl_row = k. The result is negated when sgn_neg = 1, where sgn_neg is read at (sgn_row = k, sgn_col = n). The weight of a fresh walk is 1.0 (value 2^FRAC_W).
- R5: Each new weight saturates to the range [−2^(W_W−1), 2^(W_W−1)−1].
- R6: The new weight is added to the sum only when the next state equals the latched column. A walk that never enters that column contributes 0. The starting state is never counted.
- R7: est equals the sum arithmetically shifted right by N_LOG2, saturated to W_W bits. The sum itself is wide enough that it never wraps.
- R8: done is high for exactly one cycle, two cycles after the final accepted transition. busy is high from the cycle after start until done, and low after done. est holds its value until the next result.
- R9: A start pulse while busy is ignored: the latched row and column, and therefore the result, are unchanged.
- R10: While nx_req is high and nx_vld is low, nx_req stays high, nx_cur stays stable, and no progress is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an estimate (honoured only in IDLE) |
| row_i | input | IDX_W | Row of the wanted inverse entry |
| col_j | input | IDX_W | Column of the wanted inverse entry |
| busy | output | 1 | Estimate in progress |
| nx_req | output | 1 | Request for the next walk state |
| nx_cur | output | IDX_W | Current walk state offered to the generator |
| nx_vld | input | 1 | Next state is valid (transition accepted when nx_req is also high) |
| nx_state | input | IDX_W | Next walk state |
| scl_row | output | IDX_W | Scale table address (current state) |
| scl_val | input | E_W | Unsigned row scale, FRAC_W fractional bits |
| sgn_row | output | IDX_W | Sign table row address (current state) |
| sgn_col | output | IDX_W | Sign table column address (offered next state) |
| sgn_neg | input | 1 | 1 when the entry at (sgn_row, sgn_col) is negative |
| done | output | 1 | One-cycle result strobe |
| est | output | W_W | Signed fixed-point estimate, FRAC_W fractional bits |

## Verification
The bench drives walks in which every move lands on the target column with the largest scale. This pushes the weight to both saturation rails and the final average past the output range. A design that wrapped instead of clamping would report a small or wrongly signed estimate. Further runs never visit the column, or start on the column itself, which exposes a design that counts the start state or adds weights unconditionally. Random stall gaps on the handshake, and a second start pulse with different indices in the middle of a run, catch a controller that advances without a valid transition or relatches its indices while busy. Every request is also compared against the expected current state, so a walk that fails to restart at the row is caught at its first step.

// File: rtl/mc_inv_pkg.sv
package mc_inv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEED,
        ST_STEP,
        ST_FIN,
        ST_DONE
    } mc_state_e;

endpackage

// File: rtl/mc_weight_step.sv
module mc_weight_step #(
    parameter int W_W    = 16,
    parameter int E_W    = 12,
    parameter int FRAC_W = 8
) (
    input  logic signed [W_W-1:0] w_in,
    input  logic        [E_W-1:0] e_in,
    input  logic                  neg,
    output logic signed [W_W-1:0] w_out
);
    localparam int PW = W_W + E_W + 2;
    localparam logic signed [PW-1:0] HI = PW'((64'sd1 <<< (W_W - 1)) - 64'sd1);
    localparam logic signed [PW-1:0] LO = ~HI;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic signed [PW-1:0] signed_v;

    always_comb begin
        prod     = PW'(w_in) * PW'($signed({1'b0, e_in}));
        scaled   = prod >>> FRAC_W;
        signed_v = neg ? -scaled : scaled;
        if (signed_v > HI) begin
            w_out = W_W'(HI);
        end else if (signed_v < LO) begin
            w_out = W_W'(LO);
        end else begin
            w_out = W_W'(signed_v);
        end
    end

endmodule

// File: rtl/mc_sum_acc.sv
module mc_sum_acc #(
    parameter int W_W   = 16,
    parameter int ACC_W = 24,
    parameter int SHIFT = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  add,
    input  logic signed [W_W-1:0] val,
    output logic signed [W_W-1:0] avg
);
    localparam logic signed [ACC_W-1:0] HI = ACC_W'((64'sd1 <<< (W_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] LO = ~HI;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] shr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (add) begin
            acc_q <= acc_q + ACC_W'(val);
        end
    end

    always_comb begin
        shr = acc_q >>> SHIFT;
        if (shr > HI) begin
            avg = W_W'(HI);
        end else if (shr < LO) begin
            avg = W_W'(LO);
        end else begin
            avg = W_W'(shr);
        end
    end

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0)); // R6

    AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !clr && (acc_q[ACC_W-1] == val[W_W-1])) |=> (acc_q[ACC_W-1] == $past(acc_q[ACC_W-1]))); // R7

endmodule

// File: rtl/mc_inv_est.sv
module mc_inv_est
    import mc_inv_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int W_W    = 16,
    parameter int E_W    = 12,
    parameter int FRAC_W = 8,
    parameter int T_LEN  = 8,
    parameter int N_LOG2 = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [IDX_W-1:0]      row_i,
    input  logic [IDX_W-1:0]      col_j,
    output logic                  busy,
    output logic                  nx_req,
    output logic [IDX_W-1:0]      nx_cur,
    input  logic                  nx_vld,
    input  logic [IDX_W-1:0]      nx_state,
    output logic [IDX_W-1:0]      scl_row,
    input  logic [E_W-1:0]        scl_val,
    output logic [IDX_W-1:0]      sgn_row,
    output logic [IDX_W-1:0]      sgn_col,
    input  logic                  sgn_neg,
    output logic                  done,
    output logic signed [W_W-1:0] est
);
    localparam int SB     = (T_LEN > 1) ? $clog2(T_LEN) : 1;
    localparam int CB     = (N_LOG2 > 0) ? N_LOG2 : 1;
    localparam int N_WALK = 1 << N_LOG2;
    localparam int ACC_W  = W_W + N_LOG2 + SB + 1;
    localparam logic signed [W_W-1:0] W_ONE = W_W'(1 << FRAC_W);

    mc_state_e state_q, state_d;

    logic [IDX_W-1:0]      i_q, j_q, k_q;
    logic signed [W_W-1:0] w_q, w_nx, avg, est_q;
    logic [SB-1:0]         step_q;
    logic [CB-1:0]         chain_q;
    logic                  take, last_step, last_chain, hit, clr;

    assign take       = nx_req && nx_vld;
    assign last_step  = (step_q == SB'(T_LEN - 1));
    assign last_chain = (chain_q == CB'(N_WALK - 1));
    assign hit        = take && (nx_state == j_q);
    assign clr        = (state_q == ST_IDLE) && start;

    assign nx_cur  = k_q;
    assign scl_row = k_q;
    assign sgn_row = k_q;
    assign sgn_col = nx_state;
    assign est     = est_q;

    mc_weight_step #(.W_W(W_W), .E_W(E_W), .FRAC_W(FRAC_W)) u_wstep (
        .w_in  (w_q),
        .e_in  (scl_val),
        .neg   (sgn_neg),
        .w_out (w_nx)
    );

    mc_sum_acc #(.W_W(W_W), .ACC_W(ACC_W), .SHIFT(N_LOG2)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .add   (hit),
        .val   (w_nx),
        .avg   (avg)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SEED;
            ST_SEED: state_d = ST_STEP;
            ST_STEP: begin
                if (take && last_step) begin
                    state_d = last_chain ? ST_FIN : ST_SEED;
                end
            end
            ST_FIN:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy   = 1'b1;
        nx_req = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: busy   = 1'b0;
            ST_SEED: ;
            ST_STEP: nx_req = 1'b1;
            ST_FIN:  ;
            ST_DONE: done   = 1'b1;
            default: busy   = 1'b0;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q     <= '0;
            j_q     <= '0;
            k_q     <= '0;
            w_q     <= '0;
            step_q  <= '0;
            chain_q <= '0;
            est_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        i_q     <= row_i;
                        j_q     <= col_j;
                        chain_q <= '0;
                    end
                end
                ST_SEED: begin
                    k_q    <= i_q;
                    w_q    <= W_ONE;
                    step_q <= '0;
                end
                ST_STEP: begin
                    if (take) begin
                        k_q    <= nx_state;
                        w_q    <= w_nx;
                        step_q <= step_q + SB'(1);
                        if (last_step) chain_q <= chain_q + CB'(1);
                    end
                end
                ST_FIN:  est_q <= avg;
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (nx_req && !nx_vld) |=> (nx_req && $stable(nx_cur))); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R8

    AST_SEED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEED) |=> (nx_req && (nx_cur == i_q))); // R2

    AST_IDX_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(i_q) && $stable(j_q))); // R9

    AST_NO_REQ_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last_step && last_chain) |=> !nx_req); // R3

endmodule

// File: tb/sim_mc_inv_est.sv
module sim_mc_inv_est;
    localparam int IDX_W = 5, W_W = 16, E_W = 12, FRAC_W = 8, T_LEN = 8, N_LOG2 = 3;
    localparam int NS = 1 << IDX_W;
    localparam int NW = 1 << N_LOG2;
    localparam int NH = NW * T_LEN;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, nx_vld = 1'b0;
    logic [IDX_W-1:0] row_i = '0, col_j = '0, nx_state = '0;
    logic busy, nx_req, done, sgn_neg;
    logic [IDX_W-1:0] nx_cur, scl_row, sgn_row, sgn_col;
    logic [E_W-1:0] scl_val;
    logic signed [W_W-1:0] est;

    logic [E_W-1:0] etab [NS];
    bit             stab [NS][NS];
    int             seq  [NH];
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    assign scl_val = etab[scl_row];
    assign sgn_neg = stab[sgn_row][sgn_col];

    mc_inv_est #(.IDX_W(IDX_W), .W_W(W_W), .E_W(E_W), .FRAC_W(FRAC_W),
                 .T_LEN(T_LEN), .N_LOG2(N_LOG2)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .row_i(row_i), .col_j(col_j),
        .busy(busy), .nx_req(nx_req), .nx_cur(nx_cur), .nx_vld(nx_vld),
        .nx_state(nx_state), .scl_row(scl_row), .scl_val(scl_val),
        .sgn_row(sgn_row), .sgn_col(sgn_col), .sgn_neg(sgn_neg),
        .done(done), .est(est)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint clampw(input longint v);
        longint hi = (64'sd1 <<< (W_W - 1)) - 1;
        if (v > hi) return hi;
        if (v < -hi - 1) return -hi - 1;
        return v;
    endfunction

    function automatic longint model_est(input int ri, input int rj);
        longint sum = 0;
        for (int c = 0; c < NW; c++) begin
            int k = ri;
            longint w = 64'sd1 <<< FRAC_W;
            for (int t = 0; t < T_LEN; t++) begin
                int nk = seq[c * T_LEN + t];
                longint p = (w * longint'(etab[k])) >>> FRAC_W;
                if (stab[k][nk]) p = -p;
                w = clampw(p);
                if (nk == rj) sum += w;
                k = nk;
            end
        end
        return clampw(sum >>> N_LOG2);
    endfunction

    // mode 0: biased random, 1: never the column, 2: always the column
    task automatic make_seq(input int rj, input int mode);
        for (int h = 0; h < NH; h++) begin
            int v = int'($urandom % NS);
            if (mode == 2) v = rj;
            else if (mode == 1) begin if (v == rj) v = (v + 1) % NS; end
            else if ($urandom % 4 == 0) v = rj;
            seq[h] = v;
        end
    endtask

    task automatic run_case(input int ri, input int rj, input bit gaps, input bit poke, input string tag);
        longint exp = model_est(ri, rj);
        int prev = ri;
        longint held;
        @(negedge clk);
        row_i = IDX_W'(ri); col_j = IDX_W'(rj); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {tag, " R8 busy after start"}, busy, 1);
        for (int h = 0; h < NH; h++) begin
            int cnt = 0;
            int g;
            int expc;
            while (!nx_req && cnt < 20) begin @(negedge clk); cnt++; end
            chk(nx_req == 1'b1, {tag, " R3 request present"}, nx_req, 1);
            expc = (h % T_LEN == 0) ? ri : prev;
            chk(int'(nx_cur) == expc, {tag, " R2 current state"}, nx_cur, expc);
            g = gaps ? int'($urandom % 4) : 0;
            if (poke && h == 5) g = 2;
            for (int s = 0; s < g; s++) begin
                if (poke && h == 5 && s == 0) begin
                    start = 1'b1; row_i = IDX_W'(ri ^ 3); col_j = IDX_W'(rj ^ 5);
                end
                @(negedge clk);
                start = 1'b0;
                chk(nx_req && int'(nx_cur) == expc, {tag, " R10 stall hold"}, nx_cur, expc);
            end
            nx_vld = 1'b1; nx_state = IDX_W'(seq[h]);
            @(negedge clk);
            nx_vld = 1'b0;
            prev = seq[h];
        end
        chk(!nx_req && !done, {tag, " R3 no request after last"}, nx_req, 0);
        @(negedge clk);
        chk(done == 1'b1, {tag, " R8 done timing"}, done, 1);
        chk(longint'(est) == exp, {tag, poke ? " R9 est" : " R7 est"}, est, exp);
        held = est;
        @(negedge clk);
        chk(!done && !busy, {tag, " R8 single pulse"}, done, 0);
        chk(longint'(est) == held, {tag, " R8 est held"}, est, held);
    endtask

    task automatic rand_tables();
        for (int r = 0; r < NS; r++) begin
            etab[r] = E_W'(64 + $urandom % 384);
            for (int c = 0; c < NS; c++) stab[r][c] = bit'($urandom % 2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R3 watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rand_tables();
        repeat (3) @(negedge clk);
        chk(!busy && !nx_req && !done && est == 0, "R1 reset state", est, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // positive saturation: largest scale, every move onto the column
        for (int r = 0; r < NS; r++) begin
            etab[r] = '1;
            for (int c = 0; c < NS; c++) stab[r][c] = 1'b0;
        end
        make_seq(7, 2);
        run_case(3, 7, 1'b0, 1'b0, "R5 R4 positive saturation");

        // negative saturation: first move negative, rest positive
        stab[3][7] = 1'b1;
        run_case(3, 7, 1'b0, 1'b0, "R5 R4 negative saturation");

        rand_tables();
        make_seq(9, 1);
        run_case(2, 9, 1'b1, 1'b0, "R6 column never visited");

        make_seq(4, 0);
        run_case(4, 4, 1'b1, 1'b0, "R6 start on column");

        make_seq(11, 0);
        run_case(6, 11, 1'b1, 1'b1, "R9 start while busy");

        for (int n = 0; n < 10; n++) begin
            int ri = int'($urandom % NS);
            int rj = int'($urandom % NS);
            rand_tables();
            make_seq(rj, 0);
            run_case(ri, rj, 1'b1, 1'b0, "R4 random walk");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule